// File: doc/BRIEF.md
# Pixel Span XOR-Substitute Cipher

This block transforms one 128-bit span of sixteen 8-bit gray pixels per clock, in either direction. The forward direction whitens the span with a first key, passes every byte through the standard AES forward substitution, then whitens again with a second key. The reverse direction undoes this. It strips the second key, passes every byte through the inverse substitution, then strips the first key.

A surrounding engine supplies a fresh key pair with every span, together with a direction bit and a valid strobe. The block has no rounds, no row shifting and no column mixing. It is a single substitution layer between two key layers. Its result is registered, so each span appears one clock after it is accepted, and a new span can be accepted on every clock.

Top module: `pscx_span_cipher`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_valid` = 0 and `out_span` = 0.
- R2: With `in_decrypt` = 0, each output byte is S(p XOR a) XOR b. Here p, a and b are the matching bytes of span, first key and second key. S is the AES forward substitution: the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (0 maps to 0), then the affine map with constant 0x63. An all-zero span and all-zero keys therefore give every byte 0x63.
- R3: With `in_decrypt` = 1, each output byte is Sinv(c XOR b) XOR a, where Sinv is the inverse of S.
- R4: A span accepted with `in_valid` = 1 at a rising edge produces `out_valid` = 1 and its result on `out_span` in the cycle after that edge. No result appears for a cycle with `in_valid` = 0.
- R5: Spans presented on consecutive cycles are each accepted, and the results come out in order on consecutive cycles.
- R6: Byte lanes are independent. Byte i of the result depends only on byte i of the span and of both keys. Byte 0 (pixel 0) is bits [127:120].
- R7: While `in_valid` is 0, `out_span` keeps the last result and ignores changes on the span, key and direction inputs.
- R8: Decrypting the ciphertext of an encryption with the same key pair returns the original span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Span and keys present this cycle |
| in_decrypt | input | 1 | 0 = forward direction, 1 = reverse direction |
| in_span | input | 128 | Sixteen pixels, pixel 0 in the top byte |
| in_key_a | input | 128 | First key of the pair |
| in_key_b | input | 128 | Second key of the pair |
| out_valid | output | 1 | Result present this cycle |
| out_span | output | 128 | Transformed span |

## Verification
Every result is due exactly one cycle after the rising edge that accepted its span. Nothing else is due: idle cycles produce no result and leave the output untouched. The bench drives inputs on falling edges. For each accepted span it queues the expected value, computed from its own substitution table. On each falling edge where `out_valid` is high, it pops the oldest expected value and compares it, so a late, early, missing or extra result shows as a mismatch. Idle stretches are checked on the same falling edges for a low valid and an unchanged output.

// File: rtl/pscx_pkg.sv
package pscx_pkg;
  localparam int BYTE_W = 8;

  function automatic logic [7:0] gf_mul(input logic [7:0] x, input logic [7:0] y);
    logic [7:0] acc, a;
    acc = 8'h00;
    a = x;
    for (int i = 0; i < 8; i++) begin
      if (y[i]) acc = acc ^ a;
      a = a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
    end
    return acc;
  endfunction

  // x^254 equals the inverse of x for x != 0 and yields 0 for 0
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] res, base;
    logic [7:0] e;
    res = 8'h01;
    base = x;
    e = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) res = gf_mul(res, base);
      base = gf_mul(base, base);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sub_fwd(input logic [7:0] x);
    logic [7:0] q;
    q = gf_inv(x);
    return q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sub_inv(input logic [7:0] y);
    logic [7:0] q;
    q = rotl8(y, 1) ^ rotl8(y, 3) ^ rotl8(y, 6) ^ 8'h05;
    return gf_inv(q);
  endfunction
endpackage

// File: rtl/pscx_byte_lane.sv
module pscx_byte_lane
  import pscx_pkg::*;
(
  input  logic              decrypt,
  input  logic [BYTE_W-1:0] data,
  input  logic [BYTE_W-1:0] key_a,
  input  logic [BYTE_W-1:0] key_b,
  output logic [BYTE_W-1:0] result
);
  logic [BYTE_W-1:0] pre_fwd, pre_inv, mid_fwd, mid_inv;

  always_comb begin
    pre_fwd = data ^ key_a;
    pre_inv = data ^ key_b;
    mid_fwd = sub_fwd(pre_fwd);
    mid_inv = sub_inv(pre_inv);
    result  = decrypt ? (mid_inv ^ key_a) : (mid_fwd ^ key_b);
  end
endmodule

// File: rtl/pscx_span_path.sv
module pscx_span_path
  import pscx_pkg::*;
#(
  parameter int LANES = 16,
  localparam int SPAN_W = LANES * BYTE_W
) (
  input  logic              decrypt,
  input  logic [SPAN_W-1:0] span,
  input  logic [SPAN_W-1:0] key_a,
  input  logic [SPAN_W-1:0] key_b,
  output logic [SPAN_W-1:0] result
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HI = SPAN_W - 1 - g * BYTE_W;
    pscx_byte_lane u_lane (
      .decrypt (decrypt),
      .data    (span[HI -: BYTE_W]),
      .key_a   (key_a[HI -: BYTE_W]),
      .key_b   (key_b[HI -: BYTE_W]),
      .result  (result[HI -: BYTE_W])
    );
  end
endmodule

// File: rtl/pscx_span_cipher.sv
module pscx_span_cipher
  import pscx_pkg::*;
#(
  parameter int LANES = 16,
  localparam int SPAN_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_decrypt,
  input  logic [SPAN_W-1:0] in_span,
  input  logic [SPAN_W-1:0] in_key_a,
  input  logic [SPAN_W-1:0] in_key_b,
  output logic              out_valid,
  output logic [SPAN_W-1:0] out_span
);
  logic [SPAN_W-1:0] path_result;

  pscx_span_path #(.LANES(LANES)) u_path (
    .decrypt (in_decrypt),
    .span    (in_span),
    .key_a   (in_key_a),
    .key_b   (in_key_b),
    .result  (path_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_span  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_span <= path_result;
    end
  end
endmodule

// File: rtl/pscx_span_cipher_chk.sv
module pscx_span_cipher_chk #(
  parameter int SPAN_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [SPAN_W-1:0] out_span
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_span == '0));

  p_valid_follows_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> $stable(out_span));

  p_stream_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_valid) |=> out_valid);
endmodule

bind pscx_span_cipher pscx_span_cipher_chk #(.SPAN_W(SPAN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_span  (out_span)
);

// File: tb/pscx_span_cipher_test.sv
module pscx_span_cipher_test;
  localparam int W = 128;

  typedef struct {
    logic [W-1:0] exp;
    string        req;
  } sb_item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_decrypt = 1'b0;
  logic [W-1:0] in_span = '0;
  logic [W-1:0] in_key_a = '0;
  logic [W-1:0] in_key_b = '0;
  logic         out_valid;
  logic [W-1:0] out_span;

  int n_cmp = 0;
  int n_bad = 0;
  sb_item_t sb_q[$];
  logic [7:0] fwd_t[256];
  logic [7:0] inv_t[256];
  logic [W-1:0] last_out = '0;
  bit monitor_on = 1'b0;

  always #10 clk = ~clk;

  pscx_span_cipher uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_decrypt(in_decrypt),
    .in_span(in_span), .in_key_a(in_key_a), .in_key_b(in_key_b),
    .out_valid(out_valid), .out_span(out_span)
  );

  // Build the substitution table by walking generator 3 and its inverse
  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  initial begin
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1B : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
      fwd_t[p] = x ^ 8'h63;
    end while (p != 8'h01);
    fwd_t[0] = 8'h63;
    for (int i = 0; i < 256; i++) inv_t[fwd_t[i]] = 8'(i);
  end

  function automatic logic [W-1:0] model(input logic dec, input logic [W-1:0] s,
                                         input logic [W-1:0] ka, input logic [W-1:0] kb);
    logic [W-1:0] r;
    for (int i = 0; i < 16; i++) begin
      int hi = W - 1 - 8 * i;
      if (dec) r[hi -: 8] = inv_t[s[hi -: 8] ^ kb[hi -: 8]] ^ ka[hi -: 8];
      else     r[hi -: 8] = fwd_t[s[hi -: 8] ^ ka[hi -: 8]] ^ kb[hi -: 8];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: present one span on a falling edge and queue its expectation
  task automatic send(input logic dec, input logic [W-1:0] s, input logic [W-1:0] ka,
                      input logic [W-1:0] kb, input string req);
    sb_item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_decrypt = dec; in_span = s; in_key_a = ka; in_key_b = kb;
    it.exp = model(dec, s, ka, kb);
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic send_exp(input logic dec, input logic [W-1:0] s, input logic [W-1:0] ka,
                          input logic [W-1:0] kb, input logic [W-1:0] e, input string req);
    sb_item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_decrypt = dec; in_span = s; in_key_a = ka; in_key_b = kb;
    it.exp = e;
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_decrypt = ~in_decrypt;
      in_span = {4{$urandom()}};
      in_key_a = {4{$urandom()}};
      in_key_b = {4{$urandom()}};
    end
  endtask

  // Monitor: pops the oldest expectation whenever a result is present
  always @(negedge clk) begin
    if (monitor_on && !rst) begin
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R4 actual=unexpected result %h expected=no result", out_span);
        end else begin
          sb_item_t it;
          it = sb_q.pop_front();
          check(it.req, out_span, it.exp);
        end
        last_out = out_span;
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #4000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] ka, kb, p, c;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_span", out_span, '0);
    check("R1 out_valid", {127'b0, out_valid}, '0);
    rst = 1'b0;
    monitor_on = 1'b1;

    // R2: known value, zero span and keys give 0x63 in every byte
    send_exp(1'b0, '0, '0, '0, {16{8'h63}}, "R2 known");
    // R2: assorted patterns
    send(1'b0, 128'h000102030405060708090A0B0C0D0E0F, {16{8'hA5}}, '0, "R2 ramp");
    send(1'b0, {16{8'hFF}}, 128'h0123456789ABCDEF0011223344556677, {16{8'h3C}}, "R2 white");
    // R3: reverse direction
    send(1'b1, 128'hDEADBEEF00112233445566778899AABB, {16{8'h11}}, {16{8'h22}}, "R3 dec");
    send(1'b1, {16{8'h63}}, '0, '0, "R3 dec zero");
    in_valid = 1'b1;
    idle(1);
    // R4: one idle cycle, then a lone span
    send(1'b0, 128'hCAFEF00DCAFEF00DCAFEF00DCAFEF00D, {4{32'h5A5A5A5A}}, {4{32'h0F0F0F0F}}, "R4 lone");
    idle(3);
    // R7: result held across the idle stretch with random inputs
    check("R7 hold", out_span, last_out);
    check("R7 valid low", {127'b0, out_valid}, '0);

    // R6: flip one pixel, only that lane of the result may change
    ka = 128'h1F2E3D4C5B6A79880F1E2D3C4B5A6978;
    kb = 128'h8899AABBCCDDEEFF0011223344556677;
    p  = 128'h10203040506070809000A0B0C0D0E0F0;
    send(1'b0, p, ka, kb, "R6 base");
    send(1'b0, p ^ {8'h00, 8'h80, 112'h0}, ka, kb, "R6 lane1");
    send(1'b0, p ^ {120'h0, 8'h01}, ka, kb, "R6 lane15");
    // R8: round trip, expectation is the original span itself
    c = model(1'b0, p, ka, kb);
    send_exp(1'b1, c, ka, kb, p, "R8 roundtrip");

    // R5: back-to-back stream with fresh key pairs, both directions
    for (int i = 0; i < 40; i++) begin
      send(1'(i % 3 == 0), {4{$urandom()}}, {4{$urandom()}}, {4{$urandom()}}, "R5 stream");
    end
    idle(2);
    check("R7 hold after stream", out_span, last_out);

    // R1: reset mid-run clears the output
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset", out_span, '0);
    check("R1 mid reset valid", {127'b0, out_valid}, '0);
    rst = 1'b0;
    last_out = '0;
    send(1'b0, {16{8'h53}}, '0, '0, "R2 after reset");
    idle(3);
    check("R4 queue drained", W'(sb_q.size()), '0);
    finish_run();
  end
endmodule